// File: doc/BRIEF.md
# Two-Wire Register Slave with Paged Writes

This block is the serial front end of a small register space of 32 byte locations. It watches the two open-drain lines of an I2C bus in the system clock domain. It filters and edge-detects them and recognises START, repeated START and STOP. It decides whether it is being addressed and then turns the bus traffic into byte-wide write strobes and read requests toward a register file that sits beside it. It only pulls SDA low, for its acknowledge bits and for the zero bits of read data.

The slave address comes from one of two places. A strap input can select the fixed address byte, or the block can use the seven upper bits of the stored location 00h, which the register file supplies. One memory address counter serves both directions. In a write it moves within 2-byte pages, and in a read it steps through the whole space. While the nonvolatile commit logic reports a write in progress, the slave does not acknowledge its address. A host can therefore poll for completion by repeating the address byte.

Top module: `i2c_pagewrap_slave`

## Requirements
- R1: After reset, sda_oe, wr_en and rd_req are all 0.
- R2: With addr_sel low, the slave answers only to the address byte A2h (write) or A3h (read). With addr_sel high, it compares the upper seven bits of an address byte with stored_addr[7:1]; stored_addr[0] has no effect.
- R3: In a write, the first byte after the address byte loads the counter from its 5 low bits, and bits 7:5 are ignored. Each later byte gives exactly one single-cycle wr_en pulse carrying that byte and the counter, and then advances the counter.
- R4: Within a write, advancing the counter changes only bit 0, so the writes stay inside the 2-byte page that starts at the even address.
- R5: A read transaction starts at the current counter, including the value a previous write left behind. A write of one address byte followed by a repeated START sets the point where the read starts.
- R6: The slave sends another byte after each master ACK (0). After a master NACK (1) it keeps SDA released until the next START.
- R7: If the address byte does not match, the slave NACKs it (the ninth bit reads 1) and raises no strobe and no acknowledge until the next START.
- R8: While nv_busy is 1, a matching address byte is NACKed and nothing is written. Once nv_busy is 0, the same byte is ACKed.
- R9: Bits are taken on the rising SCL edge and sent MSB first. The slave changes sda_oe only while SCL is low, and the ninth bit carries its ACK as 0.
- R10: In a read, the counter advances after each byte and wraps from 1Fh to 00h.
- R11: SCL or SDA pulses shorter than three system clocks after synchronisation are ignored. They cause no extra bit, no START and no STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_sel | input | 1 | 0: fixed address A2h/A3h; 1: address from stored_addr |
| stored_addr | input | 8 | Content of stored location 00h |
| nv_busy | input | 1 | Nonvolatile write in progress |
| wr_en | output | 1 | One-cycle write strobe |
| wr_addr | output | 5 | Write location |
| wr_data | output | 8 | Write data |
| rd_req | output | 1 | One-cycle read request; rd_data is taken in the same cycle |
| rd_addr | output | 5 | Read location (the counter) |
| rd_data | input | 8 | Register file data for rd_addr |

## Verification
Each line goes through two sync flops, a three-sample window and one edge register, so the slave reacts about six system clocks after a raw SCL edge. A write strobe or a new sda_oe value is therefore due within about seven clocks of the falling SCL edge that ends a byte or a bit. The bench holds every SCL phase for 16 clocks and changes SDA only in the middle of a low phase. It reads SDA halfway through the high phase, well after the slave has settled. Write strobes are logged as they occur and compared only after the STOP, so the checks do not depend on the exact cycle within that window.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RACK
    } slv_state_e;

    // Bus events, all derived from the filtered lines
    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic logic addr_hit(input logic [7:0] rx,
                                      input logic       sel,
                                      input logic [7:0] stored,
                                      input logic [6:0] fixed);
        logic [6:0] want;
        want = sel ? stored[7:1] : fixed;
        return rx[7:1] == want;
    endfunction

endpackage

// File: rtl/i2cs_filt.sv
module i2cs_filt #(
    parameter int   SYNC    = 2,
    parameter int   WIN     = 3,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [SYNC-1:0] sync_q;
    logic [WIN-1:0]  hist;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= {SYNC{RST_VAL}};
            hist   <= {WIN{RST_VAL}};
            dout   <= RST_VAL;
        end else begin
            sync_q <= {sync_q[SYNC-2:0], din};
            hist   <= {hist[WIN-2:0], sync_q[SYNC-1]};
            if (&hist)
                dout <= 1'b1;
            else if (~|hist)
                dout <= 1'b0;
        end
    end
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond
    import i2cs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_f,
    input  logic    sda_f,
    output bus_ev_t ev
);
    logic scl_p, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    always_comb begin
        ev.start = scl_f & scl_p & sda_p & ~sda_f;
        ev.stop  = scl_f & scl_p & ~sda_p & sda_f;
        ev.rise  = scl_f & ~scl_p;
        ev.fall  = ~scl_f & scl_p;
        ev.sda   = sda_f;
    end
endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
    import i2cs_pkg::*;
#(
    parameter int         AW     = 5,
    parameter int         DW     = 8,
    parameter int         PAGE_W = 1,
    parameter logic [6:0] FIXED  = 7'h51
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_ev_t       ev,
    input  logic          addr_sel,
    input  logic [7:0]    stored_addr,
    input  logic          nv_busy,
    output logic          sda_oe,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data
);
    localparam int CW = $clog2(DW + 1);

    slv_state_e    st;
    logic [CW-1:0] bitcnt;
    logic [DW-1:0] sh;
    logic [DW-1:0] tx;
    logic [AW-1:0] ptr;
    logic          rw;
    logic          more;
    logic          load_now;

    assign rd_addr  = ptr;
    assign load_now = ev.fall && !ev.start && !ev.stop &&
                      ((st == ST_ADDR_ACK && rw) || (st == ST_RACK && more));
    assign rd_req   = load_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            bitcnt  <= '0;
            sh      <= '0;
            tx      <= '0;
            ptr     <= '0;
            rw      <= 1'b0;
            more    <= 1'b0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (ev.stop) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (ev.start) begin
                st     <= ST_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    ST_ADDR, ST_REG, ST_WDAT: begin
                        if (ev.rise && bitcnt < CW'(DW)) begin
                            sh     <= {sh[DW-2:0], ev.sda};
                            bitcnt <= bitcnt + CW'(1);
                        end else if (ev.fall && bitcnt == CW'(DW)) begin
                            bitcnt <= '0;
                            if (st == ST_ADDR) begin
                                if (addr_hit(sh, addr_sel, stored_addr, FIXED) && !nv_busy) begin
                                    rw     <= sh[0];
                                    sda_oe <= 1'b1;
                                    st     <= ST_ADDR_ACK;
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end else if (st == ST_REG) begin
                                ptr    <= sh[AW-1:0];
                                sda_oe <= 1'b1;
                                st     <= ST_REG_ACK;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= sh;
                                ptr     <= {ptr[AW-1:PAGE_W], ptr[PAGE_W-1:0] + PAGE_W'(1)};
                                sda_oe  <= 1'b1;
                                st      <= ST_WDAT_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev.fall) begin
                            if (rw) begin
                                tx     <= rd_data;
                                sda_oe <= ~rd_data[DW-1];
                                ptr    <= ptr + AW'(1);
                                bitcnt <= '0;
                                st     <= ST_RDAT;
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= ST_REG;
                            end
                        end
                    end
                    ST_REG_ACK, ST_WDAT_ACK: begin
                        if (ev.fall) begin
                            sda_oe <= 1'b0;
                            st     <= ST_WDAT;
                        end
                    end
                    ST_RDAT: begin
                        if (ev.fall) begin
                            if (bitcnt == CW'(DW - 1)) begin
                                sda_oe <= 1'b0;
                                bitcnt <= '0;
                                st     <= ST_RACK;
                            end else begin
                                sda_oe <= ~tx[DW-2];
                                tx     <= {tx[DW-2:0], 1'b0};
                                bitcnt <= bitcnt + CW'(1);
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev.rise) begin
                            more <= ~ev.sda;
                        end else if (ev.fall) begin
                            if (more) begin
                                tx     <= rd_data;
                                sda_oe <= ~rd_data[DW-1];
                                ptr    <= ptr + AW'(1);
                                bitcnt <= '0;
                                st     <= ST_RDAT;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_pagewrap_slave.sv
module i2c_pagewrap_slave
    import i2cs_pkg::*;
#(
    parameter int         AW     = 5,
    parameter int         DW     = 8,
    parameter int         PAGE_W = 1,
    parameter int         SYNC   = 2,
    parameter int         WIN    = 3,
    parameter logic [6:0] FIXED  = 7'h51
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          sda_oe,
    input  logic          addr_sel,
    input  logic [7:0]    stored_addr,
    input  logic          nv_busy,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data
);
    logic    scl_f, sda_f;
    bus_ev_t ev;
    logic    start_det;

    i2cs_filt #(.SYNC(SYNC), .WIN(WIN), .RST_VAL(1'b1)) u_scl_filt (
        .clk(clk), .rst(rst), .din(scl_in), .dout(scl_f)
    );

    i2cs_filt #(.SYNC(SYNC), .WIN(WIN), .RST_VAL(1'b1)) u_sda_filt (
        .clk(clk), .rst(rst), .din(sda_in), .dout(sda_f)
    );

    i2cs_cond u_cond (
        .clk(clk), .rst(rst), .scl_f(scl_f), .sda_f(sda_f), .ev(ev)
    );

    assign start_det = ev.start;

    i2cs_ctrl #(.AW(AW), .DW(DW), .PAGE_W(PAGE_W), .FIXED(FIXED)) u_ctrl (
        .clk(clk),
        .rst(rst),
        .ev(ev),
        .addr_sel(addr_sel),
        .stored_addr(stored_addr),
        .nv_busy(nv_busy),
        .sda_oe(sda_oe),
        .wr_en(wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_req(rd_req),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk #(
    parameter int AW     = 5,
    parameter int PAGE_W = 1
) (
    input logic          clk,
    input logic          rst,
    input logic          sda_oe,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic          rd_req,
    input logic [AW-1:0] rd_addr,
    input logic          scl_f,
    input logic          start_det
);
    logic          seen_wr, seen_rd;
    logic [AW-1:0] last_wr, last_rd;

    always_ff @(posedge clk) begin
        if (rst || start_det) begin
            seen_wr <= 1'b0;
            seen_rd <= 1'b0;
            last_wr <= '0;
            last_rd <= '0;
        end else begin
            if (wr_en) begin
                seen_wr <= 1'b1;
                last_wr <= wr_addr;
            end
            if (rd_req) begin
                seen_rd <= 1'b1;
                last_rd <= rd_addr;
            end
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sda_oe && !wr_en && !rd_req));

    // R3
    wr_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // R4
    page_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && seen_wr) |->
            (wr_addr[AW-1:PAGE_W] == last_wr[AW-1:PAGE_W] &&
             wr_addr[PAGE_W-1:0] == last_wr[PAGE_W-1:0] + PAGE_W'(1)));

    // R10
    rd_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && seen_rd) |-> (rd_addr == last_rd + AW'(1)));

    // R9
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_f);

    // R3
    no_wr_rd_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && rd_req));
endmodule

bind i2c_pagewrap_slave i2cs_chk #(.AW(AW), .PAGE_W(PAGE_W)) u_chk (
    .clk(clk),
    .rst(rst),
    .sda_oe(sda_oe),
    .wr_en(wr_en),
    .wr_addr(wr_addr),
    .rd_req(rd_req),
    .rd_addr(rd_addr),
    .scl_f(scl_f),
    .start_det(start_det)
);

// File: tb/i2c_pagewrap_slave_tb.sv
`timescale 1ns/1ps
module i2c_pagewrap_slave_tb_top;
    localparam int Q = 16;

    // {reg, count, d0, d1, d2, exp_a0, exp_a1, exp_a2}
    localparam logic [63:0] WVEC [4] = '{
        {8'h02, 8'd1, 8'hAA, 8'h00, 8'h00, 8'h02, 8'h00, 8'h00},
        {8'h06, 8'd2, 8'h11, 8'h22, 8'h00, 8'h06, 8'h07, 8'h00},
        {8'h09, 8'd3, 8'h33, 8'h44, 8'h55, 8'h09, 8'h08, 8'h09},
        {8'h1E, 8'd3, 8'h66, 8'h77, 8'h88, 8'h1E, 8'h1F, 8'h1E}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic addr_sel = 1'b0;
    logic [7:0] stored_addr = 8'h00;
    logic nv_busy = 1'b0;
    logic glitch_en = 1'b0;
    logic done = 1'b0;

    logic       sda_oe, wr_en, rd_req;
    logic [4:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data;
    logic       sda_line;

    logic [7:0] mem [32];
    logic [7:0] exp_mem [32];
    logic [4:0] wlog_a [64];
    logic [7:0] wlog_d [64];
    int wcnt = 0;
    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign rd_data  = mem[rd_addr];

    i2c_pagewrap_slave dut_i (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
        .addr_sel(addr_sel), .stored_addr(stored_addr), .nv_busy(nv_busy),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 32; i++) mem[i] <= 8'(i * 7 + 3);
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
            wlog_a[wcnt & 63] <= wr_addr;
            wlog_d[wcnt & 63] <= wr_data;
            wcnt <= wcnt + 1;
        end
    end

    task automatic chk(input logic ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_bit(input logic b, output logic r);
        sda_m = b;
        tick(Q);
        scl_m = 1'b1;
        tick(Q / 2);
        if (glitch_en) begin
            scl_m = 1'b0; tick(2); scl_m = 1'b1;
            tick(2);
            sda_m = ~b; tick(2); sda_m = b;
            tick(2);
        end
        r = sda_line;
        tick(Q / 2);
        scl_m = 1'b0;
        tick(Q);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], r);
        bus_bit(1'b1, ack);
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic nack);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, r);
            d[i] = r;
        end
        bus_bit(nack, r);
    endtask

    initial begin
        logic ack;
        logic [7:0] d;
        int base;
        logic [4:0] a;

        for (int i = 0; i < 32; i++) exp_mem[i] = 8'(i * 7 + 3);
        tick(10);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
        chk(wr_en == 1'b0, "R1 wr_en after reset", wr_en, 0);
        chk(rd_req == 1'b0, "R1 rd_req after reset", rd_req, 0);
        tick(20);

        // R3 R4 table of write transactions
        for (int v = 0; v < 4; v++) begin
            int n;
            n = int'(WVEC[v][55:48]);
            base = wcnt;
            bus_start();
            send_byte(8'hA2, ack);
            chk(ack == 1'b0, "R2 A2h acked", ack, 0);
            send_byte(WVEC[v][63:56], ack);
            chk(ack == 1'b0, "R3 register byte acked", ack, 0);
            for (int k = 0; k < n; k++) begin
                send_byte(WVEC[v][47 - 8*k -: 8], ack);
                chk(ack == 1'b0, "R9 data ACK bit", ack, 0);
            end
            bus_stop();
            chk(wcnt - base == n, "R3 strobe count", wcnt - base, n);
            for (int k = 0; k < n; k++) begin
                a = WVEC[v][20 - 8*k -: 5];
                chk(wlog_a[(base + k) & 63] == a, "R4 page wrap write address",
                    wlog_a[(base + k) & 63], a);
                chk(wlog_d[(base + k) & 63] == WVEC[v][47 - 8*k -: 8], "R3 write data",
                    wlog_d[(base + k) & 63], WVEC[v][47 - 8*k -: 8]);
                exp_mem[a] = WVEC[v][47 - 8*k -: 8];
            end
        end

        // R5 current-address read: counter left at 1Fh; R10 wrap to 00h
        bus_start();
        send_byte(8'hA3, ack);
        chk(ack == 1'b0, "R2 A3h acked", ack, 0);
        recv_byte(d, 1'b0);
        chk(d == exp_mem[31], "R5 read at current counter", d, exp_mem[31]);
        recv_byte(d, 1'b1);
        chk(d == exp_mem[0], "R10 read wrap 1Fh to 00h", d, exp_mem[0]);
        chk(sda_oe == 1'b0, "R6 released after NACK", sda_oe, 0);
        bus_bit(1'b1, ack);
        chk(ack == 1'b1, "R6 line stays released", ack, 1);
        bus_stop();

        // R5 dummy write then repeated START
        bus_start();
        send_byte(8'hA2, ack);
        send_byte(8'h1E, ack);
        bus_rstart();
        send_byte(8'hA3, ack);
        chk(ack == 1'b0, "R5 read address acked after repeated START", ack, 0);
        recv_byte(d, 1'b0);
        chk(d == exp_mem[30], "R5 read at set counter", d, exp_mem[30]);
        recv_byte(d, 1'b0);
        chk(d == exp_mem[31], "R6 next byte after ACK", d, exp_mem[31]);
        recv_byte(d, 1'b1);
        chk(d == exp_mem[0], "R10 wrap in multi-byte read", d, exp_mem[0]);
        bus_stop();

        // R7 wrong address ignored
        base = wcnt;
        bus_start();
        send_byte(8'hA4, ack);
        chk(ack == 1'b1, "R7 foreign address NACK", ack, 1);
        send_byte(8'h02, ack);
        chk(ack == 1'b1, "R7 later byte not acked", ack, 1);
        send_byte(8'h5A, ack);
        bus_stop();
        chk(wcnt == base, "R7 no strobe for foreign address", wcnt - base, 0);

        // R3 upper register bits ignored
        base = wcnt;
        bus_start();
        send_byte(8'hA2, ack);
        send_byte(8'hE5, ack);
        send_byte(8'h99, ack);
        bus_stop();
        chk(wlog_a[base & 63] == 5'h05, "R3 register byte bits 7:5 ignored", wlog_a[base & 63], 5);
        exp_mem[5] = 8'h99;

        // R8 busy suppresses the address ACK
        nv_busy = 1'b1;
        base = wcnt;
        bus_start();
        send_byte(8'hA2, ack);
        chk(ack == 1'b1, "R8 NACK while busy", ack, 1);
        send_byte(8'h03, ack);
        send_byte(8'h12, ack);
        bus_stop();
        chk(wcnt == base, "R8 no write while busy", wcnt - base, 0);
        nv_busy = 1'b0;
        bus_start();
        send_byte(8'hA2, ack);
        chk(ack == 1'b0, "R8 ACK once idle", ack, 0);
        bus_stop();

        // R2 stored address, bit 0 ignored
        addr_sel = 1'b1;
        stored_addr = 8'h6D;
        bus_start();
        send_byte(8'hA2, ack);
        chk(ack == 1'b1, "R2 fixed address refused when strap high", ack, 1);
        bus_stop();
        base = wcnt;
        bus_start();
        send_byte(8'h6C, ack);
        chk(ack == 1'b0, "R2 stored address acked", ack, 0);
        send_byte(8'h10, ack);
        send_byte(8'h42, ack);
        bus_stop();
        chk(wcnt - base == 1 && wlog_d[base & 63] == 8'h42, "R2 write via stored address",
            wlog_d[base & 63], 8'h42);
        addr_sel = 1'b0;

        // R11 short glitches on both lines
        base = wcnt;
        glitch_en = 1'b1;
        bus_start();
        send_byte(8'hA2, ack);
        chk(ack == 1'b0, "R11 address survives glitches", ack, 0);
        send_byte(8'h12, ack);
        send_byte(8'h5C, ack);
        glitch_en = 1'b0;
        bus_stop();
        chk(wcnt - base == 1, "R11 single strobe", wcnt - base, 1);
        chk(wlog_a[base & 63] == 5'h12 && wlog_d[base & 63] == 8'h5C, "R11 data intact",
            wlog_d[base & 63], 8'h5C);

        done = 1'b1;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule